// File: doc/BRIEF.md
# Four-to-One Sample Serializer

This block sits in front of a fast data converter and turns a wide, slow word stream into a narrow, fast sample stream. Each 32-bit input word carries four 8-bit samples. The block takes one word every four fast clock cycles and presents its samples one at a time on an 8-bit output, one sample per fast cycle. This lets a pattern source that runs at a quarter of the converter rate still drive the converter at its full rate.

A 2-bit phase counter advances every fast cycle. The lane to present is the bitwise complement of the count, so the most significant sample of each word goes out first. When the count reaches its last value, a take strobe tells the source that the next word is due. The word present on that edge is copied into a holding register, and the input is ignored at every other time. Each output bit has its own four-way selector, and all selectors share one select. The output is registered, so it lags the selector by one fast cycle. Lane width and lane count are parameters. The lane count must be a power of two, at least two.

Top module: `sample_serializer`

## Requirements
- R1: While `rst_i` is high at a clock edge, the phase count returns to 0, `sample_o` becomes 0 and `take_o` is low. After reset is released, `take_o` first rises in the fourth cycle, that is, after three cycles with it low.
- R2: `take_o` is high in exactly one cycle of every four, and is never high in two cycles in a row.
- R3: `wide_i` is copied into the holding register only on a clock edge where `take_o` is high. A value on `wide_i` at any other edge has no effect on `sample_o`.
- R4: After a word W is taken, `sample_o` shows W[31:24], W[23:16], W[15:8] and W[7:0] in four consecutive cycles, in that order. Lane index equals the bitwise complement of the phase count.
- R5: The first sample of a taken word appears on `sample_o` two edges after the capture edge. The output register adds one cycle after the selector.
- R6: Each sample stays on `sample_o` for exactly one fast cycle. The stream has no gaps, so the last sample of one word is followed directly by the first sample of the next.
- R7: The lane count parameter must be a power of two and at least 2. Any other value is rejected during elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast (converter-rate) clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wide_i | input | 32 | Four packed samples; lane 3 is bits [31:24], lane 0 is bits [7:0] |
| take_o | output | 1 | High for the one cycle in four when the next word is captured |
| sample_o | output | 8 | Registered output sample, one per fast cycle |

## Verification
The hardest condition to create from the ports is showing that `wide_i` has no effect between capture edges. When the source behaves correctly, the input never changes at those times, so nothing would expose a design that samples it there. The bench therefore drives unrelated values onto `wide_i` at every edge where `take_o` is low, and it puts the real word on only in the cycle where `take_o` is high. Any leak then shows up as a wrong sample. The bench sweeps 256 words, so that every byte value passes through every lane. It also applies a reset in the middle of the stream and checks that the phase restarts at the point R1 gives.

// File: rtl/ser_pkg.sv
package ser_pkg;
   // True when n is a power of two no smaller than two
   function automatic bit lanes_ok(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   // Width of a counter that walks all lanes
   function automatic int phase_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ser_phase_ctr.sv
module ser_phase_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [CNT_W-1:0] phase_o,
   output logic             last_o
);
   localparam logic [CNT_W-1:0] PH_LAST = {CNT_W{1'b1}};

   logic [CNT_W-1:0] phase_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) phase_q <= '0;
      else       phase_q <= phase_q + 1'b1;
   end

   assign phase_o = phase_q;
   assign last_o  = (phase_q == PH_LAST);

   AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (phase_q == CNT_W'($past(phase_q) + 1'b1))); // R2
   AST_LAST_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      last_o |=> !last_o); // R2
endmodule

// File: rtl/ser_word_hold.sv
module ser_word_hold #(
   parameter int WORD_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] d_i,
   output logic [WORD_W-1:0] q_o
);
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       word_q <= '0;
      else if (load_i) word_q <= d_i;
   end

   assign q_o = word_q;

   AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_i |=> $stable(word_q)); // R3
   AST_HOLD_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> (word_q == $past(d_i))); // R3
endmodule

// File: rtl/ser_lane_sel.sv
module ser_lane_sel #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   parameter int CNT_W  = 2
) (
   input  logic [LANE_W*LANES-1:0] word_i,
   input  logic [CNT_W-1:0]        phase_i,
   output logic [LANE_W-1:0]       lane_o
);
   // Lane index is the complement of the phase: the top lane goes first
   logic [CNT_W-1:0] idx;
   assign idx = ~phase_i;

   for (genvar b = 0; b < LANE_W; b++) begin : g_bit
      logic [LANES-1:0] col;
      for (genvar l = 0; l < LANES; l++) begin : g_col
         assign col[l] = word_i[l*LANE_W + b];
      end
      if (LANES == 4) begin : g_four
         always_comb begin
            case (idx)
               2'd0:    lane_o[b] = col[0];
               2'd1:    lane_o[b] = col[1];
               2'd2:    lane_o[b] = col[2];
               default: lane_o[b] = col[3];
            endcase
         end
      end else begin : g_any
         assign lane_o[b] = col[idx];
      end
   end
endmodule

// File: rtl/sample_serializer.sv
module sample_serializer #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic [LANE_W*LANES-1:0] wide_i,
   output logic                    take_o,
   output logic [LANE_W-1:0]       sample_o
);
   import ser_pkg::*;

   localparam int WORD_W = LANE_W * LANES;
   localparam int CNT_W  = phase_bits(LANES);

   initial begin : p_param_chk
      AST_LANES_POW2: assert (lanes_ok(LANES) && LANE_W >= 1)
         else $error("lane count must be a power of two >= 2"); // R7
   end

   logic [CNT_W-1:0]  phase;
   logic              last;
   logic [WORD_W-1:0] held;
   logic [LANE_W-1:0] lane;
   logic [LANE_W-1:0] out_q;
   logic [LANE_W-1:0] top_in;

   ser_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .phase_o(phase),
      .last_o (last)
   );

   ser_word_hold #(.WORD_W(WORD_W)) u_hold (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .load_i(last),
      .d_i   (wide_i),
      .q_o   (held)
   );

   ser_lane_sel #(.LANE_W(LANE_W), .LANES(LANES), .CNT_W(CNT_W)) u_sel (
      .word_i (held),
      .phase_i(phase),
      .lane_o (lane)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) out_q <= '0;
      else       out_q <= lane;
   end

   assign take_o   = last;
   assign sample_o = out_q;
   assign top_in   = wide_i[WORD_W-1 -: LANE_W];

   AST_RST_CLEAR: assert property (@(posedge clk_i)
      rst_i |=> (sample_o == '0 && !take_o)); // R1
   AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (sample_o == $past(lane))); // R5
   AST_TOP_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
      take_o |=> ##1 (sample_o == $past(top_in, 2))); // R4
endmodule

// File: tb/sim_sample_serializer.sv
module sim_sample_serializer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] wide = '0;
   logic        take;
   logic [7:0]  samp;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   sample_serializer u0 (
      .clk_i   (clk),
      .rst_i   (rst),
      .wide_i  (wide),
      .take_o  (take),
      .sample_o(samp)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] lane_of(input logic [31:0] w, input int l);
      return w[l*8 +: 8];
   endfunction

   function automatic logic [31:0] word_of(input int k);
      logic [31:0] w;
      for (int l = 0; l < 4; l++) w[l*8 +: 8] = 8'((k + 64*l) ^ (l * 8'h5a));
      return w;
   endfunction

   initial begin : watchdog
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] prev;
      logic [31:0] cur;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: phase 0 just after reset, output cleared
      chk("R1 reset out", {24'd0, samp}, 32'd0);
      chk("R1 reset take", {31'd0, take}, 32'd0);
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         wide = 32'hdead_beef ^ i;
         chk("R1 take low", {31'd0, take}, 32'd0);
         chk("R1 out zero", {24'd0, samp}, 32'd0);
      end
      prev = '0;
      for (int k = 0; k < 256; k++) begin
         cur = word_of(k);
         @(negedge clk);
         chk("R2 take high", {31'd0, take}, 32'd1);
         chk("R6 tail lane1", {24'd0, samp}, {24'd0, lane_of(prev, 1)});
         wide = cur;
         @(negedge clk);
         wide = ~cur;  // R3: junk off the capture edge
         chk("R2 take low", {31'd0, take}, 32'd0);
         chk("R5 prev lane0", {24'd0, samp}, {24'd0, lane_of(prev, 0)});
         @(negedge clk);
         wide = cur + 32'h1357_9bdf;
         chk("R4 lane3 first", {24'd0, samp}, {24'd0, lane_of(cur, 3)});
         chk("R2 take low", {31'd0, take}, 32'd0);
         @(negedge clk);
         wide = 32'h0;
         chk("R4 lane2", {24'd0, samp}, {24'd0, lane_of(cur, 2)});
         chk("R3 ignore", {31'd0, take}, 32'd0);
         prev = cur;
      end
      // Mid-stream reset
      @(negedge clk);
      chk("R4 lane1", {24'd0, samp}, {24'd0, lane_of(prev, 1)});
      rst = 1'b1;
      wide = 32'hffff_ffff;
      @(negedge clk);
      chk("R1 mid out", {24'd0, samp}, 32'd0);
      chk("R1 mid take", {31'd0, take}, 32'd0);
      rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk("R1 restart low", {31'd0, take}, 32'd0);
         chk("R1 restart out", {24'd0, samp}, 32'd0);
         @(negedge clk);
      end
      chk("R1 restart take", {31'd0, take}, 32'd1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule